// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps calendar time as seconds, minutes, hours, day of month, month, two-digit year and century. It is advanced by a one-pulse-per-second tick input and is reached through a small 32-bit register bus. The bus has a byte address, a write enable, write data and a combinational read data path.

Software presets the time by first setting an unlock bit in the control register and then writing the two packed time words. Any write to the control register, or to an unlocked time word, reloads the running calendar from the stored time words. While the enable bit is set, reads of a time word return the live calendar. While it is clear, they return the word exactly as it was last stored. The calendar rolls over correctly across month lengths, leap years and the century boundary.

Top module: `cal_rtc`

## Requirements
- R1: After reset the time words and the control register all read zero, so the clock starts disabled and locked.
- R2: Time word 1 sits at byte offset 0x00. It packs the second in bits [5:0], the minute in [13:8], the hour in [20:16] and the day of month in [28:24]. All other bits of a live read are zero.
- R3: Time word 2 sits at offset 0x04. It packs the month (1 to 12) in bits [3:0], the year within the century in [14:8] and the century in [20:16]. All other bits of a live read are zero.
- R4: While control bit 1 (unlock) is clear, a write to either time word is dropped. Neither the stored word nor the running time changes.
- R5: The control register at offset 0x10 is always writable and reads back the full written value. Bit 0 is enable and bit 1 is unlock. Writing it reloads the running time from the stored time words.
- R6: A time-word read returns the live calendar while enable is set. While enable is clear, it returns the last stored 32-bit word unchanged, reserved bits included.
- R7: The alarm location (0x08), the alarm status location (0x14) and the unmapped offsets 0x0C, 0x18 and 0x1C read as zero and ignore writes.
- R8: Each counted tick adds one second. The second wraps 59→0 into the minute, the minute wraps 59→0 into the hour, and the hour wraps 23→0 into the day.
- R9: After the last day of a month the day wraps to 1 and the month advances. Months 4, 6, 9 and 11 have 30 days, and the other non-February months have 31. Month 12 wraps to 1 and advances the year.
- R10: February has 29 days when the full year (century×100 + year) is divisible by 4 and not by 100, or is divisible by 400. Otherwise it has 28.
- R11: Year 99 wraps to 0 and advances the century.
- R12: A tick is counted only while enable is set and no bus write happens in the same cycle. A write cycle discards the tick, even when the write itself is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and state |

## Verification
Read data is combinational, so a result is due in the same cycle the address is presented. The bench drives the address at the falling edge and samples one nanosecond later, well before the next rising edge. A write or a tick changes state at the next rising edge, so the effect shows on the first read after that edge.

The bench therefore applies every stimulus for exactly one rising edge and reads back only after it. All expected calendar values come from second counts and leap-year arithmetic computed in the bench. The rollover sweep covers every month across leap, non-leap, century and 400-year cases.

// File: rtl/cal_rtc.sv
module cal_rtc #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IX_T1  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_T2  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_CTL = IDX_W'(4);

  logic [31:0] t1_q, t2_q, ctl_q;
  logic [5:0]  sec_q, min_q;
  logic [4:0]  hr_q, day_q, cen_q;
  logic [3:0]  mon_q;
  logic [6:0]  yr_q;

  logic [IDX_W-1:0] idx;
  assign idx = bus_addr[ADDR_W-1:2];

  logic en, unl;
  assign en  = ctl_q[0];
  assign unl = ctl_q[1];

  logic wr_t1, wr_t2, wr_ctl, load, step;
  assign wr_t1  = bus_we && (idx == IX_T1) && unl;
  assign wr_t2  = bus_we && (idx == IX_T2) && unl;
  assign wr_ctl = bus_we && (idx == IX_CTL);
  assign load   = wr_t1 || wr_t2 || wr_ctl;
  assign step   = tick_i && en && !bus_we;

  logic [31:0] src1, src2;
  assign src1 = wr_t1 ? bus_wdata : t1_q;
  assign src2 = wr_t2 ? bus_wdata : t2_q;

  logic leap;
  assign leap = (yr_q == 7'd0) ? (cen_q[1:0] == 2'd0) : (yr_q[1:0] == 2'd0);

  logic [4:0] mdays;
  always_comb begin
    case (mon_q)
      4'd2:                      mdays = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   mdays = 5'd30;
      default:                   mdays = 5'd31;
    endcase
  end

  logic c_s, c_m, c_h, c_d, c_mo, c_y;
  assign c_s  = sec_q >= 6'd59;
  assign c_m  = c_s  && (min_q >= 6'd59);
  assign c_h  = c_m  && (hr_q  >= 5'd23);
  assign c_d  = c_h  && (day_q >= mdays);
  assign c_mo = c_d  && (mon_q >= 4'd12);
  assign c_y  = c_mo && (yr_q  >= 7'd99);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1_q  <= '0;
      t2_q  <= '0;
      ctl_q <= '0;
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      day_q <= '0;
      mon_q <= '0;
      yr_q  <= '0;
      cen_q <= '0;
    end else if (load) begin
      if (wr_t1)  t1_q  <= bus_wdata;
      if (wr_t2)  t2_q  <= bus_wdata;
      if (wr_ctl) ctl_q <= bus_wdata;
      sec_q <= src1[5:0];
      min_q <= src1[13:8];
      hr_q  <= src1[20:16];
      day_q <= src1[28:24];
      mon_q <= src2[3:0];
      yr_q  <= src2[14:8];
      cen_q <= src2[20:16];
    end else if (step) begin
      sec_q <= c_s ? 6'd0 : sec_q + 6'd1;
      if (c_s)  min_q <= c_m ? 6'd0 : min_q + 6'd1;
      if (c_m)  hr_q  <= c_h ? 5'd0 : hr_q + 5'd1;
      if (c_h)  day_q <= c_d ? 5'd1 : day_q + 5'd1;
      if (c_d)  mon_q <= c_mo ? 4'd1 : mon_q + 4'd1;
      if (c_mo) yr_q  <= c_y ? 7'd0 : yr_q + 7'd1;
      if (c_y)  cen_q <= cen_q + 5'd1;
    end
  end

  logic [31:0] live1, live2;
  assign live1 = {3'b0, day_q, 3'b0, hr_q, 2'b0, min_q, 2'b0, sec_q};
  assign live2 = {11'b0, cen_q, 1'b0, yr_q, 4'b0, mon_q};

  always_comb begin
    case (idx)
      IX_T1:   bus_rdata = en ? live1 : t1_q;
      IX_T2:   bus_rdata = en ? live2 : t2_q;
      IX_CTL:  bus_rdata = ctl_q;
      default: bus_rdata = '0;
    endcase
  end

  // R4
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !unl && (idx == IX_T1 || idx == IX_T2)) |=> ($stable(t1_q) && $stable(t2_q)));

  // R8
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && en && !bus_we && sec_q < 6'd59) |=> (sec_q == $past(sec_q) + 6'd1));

  // R8
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && sec_q <= 6'd59) |=> (sec_q <= 6'd59));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !tick_i) |=> $stable({sec_q, min_q, hr_q, day_q, mon_q, yr_q, cen_q}));

  // R10
  feb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && en && !bus_we && mon_q == 4'd2 && day_q == 5'd28 && hr_q == 5'd23 &&
     min_q == 6'd59 && sec_q == 6'd59 && !leap) |=> (day_q == 5'd1 && mon_q == 4'd3));
endmodule

// File: tb/cal_rtc_bench.sv
`timescale 1ns/1ps
module cal_rtc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cal_rtc #(.ADDR_W(5)) u_cal_rtc (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [31:0] pk1(int d, int h, int m, int s);
    return (32'(d) << 24) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  function automatic logic [31:0] pk2(int c, int y, int mo);
    return (32'(c) << 16) | (32'(y) << 8) | 32'(mo);
  endfunction

  function automatic int mlen(int mo, int y, int c);
    int full;
    full = c * 100 + y;
    if (mo == 2) return ((full % 4 == 0 && full % 100 != 0) || full % 400 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, bit tk = 1'b0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick_i = tk;
    @(negedge clk);
    bus_we = 1'b0; tick_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick1();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic load(logic [31:0] w1, logic [31:0] w2);
    wr(5'h10, 32'h2);
    wr(5'h00, w1);
    wr(5'h04, w2);
    wr(5'h10, 32'h3);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r1, r2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(5'h00, r1); chk("R1 word1 reset", r1, 32'h0);
    rd(5'h04, r1); chk("R1 word2 reset", r1, 32'h0);
    rd(5'h10, r1); chk("R1 ctrl reset", r1, 32'h0);

    wr(5'h00, 32'h0102_0304);
    rd(5'h00, r1); chk("R4 locked write word1", r1, 32'h0);
    wr(5'h10, 32'h1);
    rd(5'h00, r1); chk("R4 locked live word1", r1, 32'h0);

    wr(5'h10, 32'hA5A5_0002);
    rd(5'h10, r1); chk("R5 ctrl readback", r1, 32'hA5A5_0002);
    wr(5'h00, 32'hE0E0_C0C0 | pk1(17, 9, 42, 7));
    wr(5'h04, 32'hFFE0_80F0 | pk2(20, 24, 6));
    rd(5'h00, r1); chk("R6 disabled word1 stored", r1, 32'hE0E0_C0C0 | pk1(17, 9, 42, 7));
    rd(5'h04, r1); chk("R6 disabled word2 stored", r1, 32'hFFE0_80F0 | pk2(20, 24, 6));
    wr(5'h10, 32'h3);
    rd(5'h00, r1); chk("R2 live word1 fields", r1, pk1(17, 9, 42, 7));
    rd(5'h04, r1); chk("R3 live word2 fields", r1, pk2(20, 24, 6));

    tick1();
    rd(5'h00, r1); chk("R8 one tick", r1, pk1(17, 9, 42, 8));
    wr(5'h08, 32'hFFFF_FFFF, 1'b1);
    rd(5'h00, r1); chk("R12 tick with write discarded", r1, pk1(17, 9, 42, 8));
    wr(5'h10, 32'h3, 1'b1);
    rd(5'h00, r1); chk("R5 ctrl write reloads stored time", r1, pk1(17, 9, 42, 7));

    rd(5'h08, r1); chk("R7 alarm reads zero", r1, 32'h0);
    foreach (r2[i]) begin end
    wr(5'h14, 32'h1234_5678);
    rd(5'h14, r1); chk("R7 status reads zero", r1, 32'h0);
    wr(5'h0C, 32'h1);
    rd(5'h0C, r1); chk("R7 hole 0x0C zero", r1, 32'h0);
    rd(5'h18, r1); chk("R7 hole 0x18 zero", r1, 32'h0);
    rd(5'h1C, r1); chk("R7 hole 0x1C zero", r1, 32'h0);
    rd(5'h10, r1); chk("R7 ctrl untouched", r1, 32'h3);
    rd(5'h00, r1); chk("R7 time untouched", r1, pk1(17, 9, 42, 7));

    load(pk1(5, 23, 58, 0), pk2(20, 21, 3));
    for (int k = 1; k <= 150; k++) begin
      int t, d;
      tick1();
      t = 23 * 3600 + 58 * 60 + k;
      d = 5;
      if (t >= 86400) begin t -= 86400; d = 6; end
      rd(5'h00, r1);
      chk("R8 second sweep", r1, pk1(d, t / 3600, (t / 60) % 60, t % 60));
    end

    for (int ci = 0; ci < 3; ci++) begin
      for (int yi = 0; yi < 5; yi++) begin
        for (int mo = 1; mo <= 12; mo++) begin
          int c, y, nd, nm, ny, nc;
          c = (ci == 0) ? 19 : (ci == 1) ? 20 : 21;
          y = (yi == 0) ? 0 : (yi == 1) ? 1 : (yi == 2) ? 4 : (yi == 3) ? 96 : 99;
          nd = mlen(mo, y, c);
          load(pk1(nd, 23, 59, 59), pk2(c, y, mo));
          tick1();
          nm = (mo == 12) ? 1 : mo + 1;
          ny = (mo == 12) ? ((y == 99) ? 0 : y + 1) : y;
          nc = (mo == 12 && y == 99) ? c + 1 : c;
          rd(5'h00, r1); chk("R9 month end word1", r1, pk1(1, 0, 0, 0));
          rd(5'h04, r2); chk("R11 month end word2", r2, pk2(nc, ny, nm));
          if (mo == 2) begin
            load(pk1(28, 23, 59, 59), pk2(c, y, 2));
            tick1();
            rd(5'h00, r1);
            rd(5'h04, r2);
            if (nd == 29) begin
              chk("R10 leap feb 29 word1", r1, pk1(29, 0, 0, 0));
              chk("R10 leap feb 29 word2", r2, pk2(c, y, 2));
            end else begin
              chk("R10 common feb end word1", r1, pk1(1, 0, 0, 0));
              chk("R10 common feb end word2", r2, pk2(c, y, 3));
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule